// File: doc/BRIEF.md
# Receiver Electrical Idle Inference

This block tells a serial-link receiver when to report electrical idle without any analog squelch. It watches the decoded receive-symbol stream and decides from missing traffic. A 3-bit link-state select and a Gen1/Gen2 rate input choose which event is expected and how long a window may pass without it. When a whole window goes by without the expected event, the idle output rises. It falls as soon as the expected event arrives.

The symbol stream carries one 10-bit symbol per valid strobe, so windows given in unit intervals are counted in symbols. A 1280 UI window is 128 symbols, 2000 UI is 200 symbols and 16000 UI is 1600 symbols. The 128 µs window is counted in receive-clock cycles and is a parameter. Windows run back to back. Any change of select or rate restarts the window. When the select has its top bit clear, the block does no timing and the output repeats the electrical-idle ordered-set detection input.

Top module: `rx_idle_infer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `idle_o` is 0 after that edge.
- R2: When `mode_sel[2]` is 0, `idle_o` takes the value `eios_seen` had in the previous cycle, whatever the other inputs are.
- R3: With `mode_sel` = 3'b100, at either rate, `idle_o` rises after a window of `US_CYCLES` clock cycles that contained no symbol with `skp_done` set.
- R4: With `mode_sel` = 3'b101, at either rate, `idle_o` rises after a window of 128 valid symbols that contained no symbol with `ts_done` set.
- R5: With `mode_sel` = 3'b110, `idle_o` rises after a window without an idle exit. The window is 200 valid symbols when `rate_gen2` = 0 and 1600 when `rate_gen2` = 1.
- R6: With `mode_sel` = 3'b111 and `rate_gen2` = 0, `idle_o` rises after a window of `US_CYCLES` clock cycles without an idle exit.
- R7: With `mode_sel` = 3'b111 and `rate_gen2` = 1, `idle_o` stays 0.
- R8: An idle exit means that four valid symbols with `com_seen` set arrived in the current window. Three are not enough.
- R9: In the timed modes `eios_seen` has no effect. Event flags count only on cycles where `sym_valid` is 1.
- R10: The expected event clears `idle_o` on the next edge. If the event falls on the last unit of a window, that window counts as satisfied.
- R11: Any change of `mode_sel` or `rate_gen2` into a timed mode clears `idle_o`, clears the event counts and starts a new full window.
- R12: Symbol-counted windows (3'b101, 3'b110) do not advance on cycles where `sym_valid` is 0.

Window ends are counted from the cycle after a configuration change. The window-end cycle is the last counted unit of that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | One decoded symbol is present this cycle |
| com_seen | input | 1 | The symbol is a COM (K28.5) |
| skp_done | input | 1 | A skip ordered set completed with this symbol |
| ts_done | input | 1 | A TS1 or TS2 ordered set completed with this symbol |
| eios_seen | input | 1 | Electrical-idle ordered set detected |
| mode_sel | input | 3 | Link-state select code |
| rate_gen2 | input | 1 | 0 = Gen1, 1 = Gen2 |
| idle_o | output | 1 | Registered electrical-idle indication |

## Verification
The window end and the arrival of the expected event can land in the same cycle. In that case the window must be credited and must not raise idle. The bench provokes this in the 3'b110 Gen1 mode. Idle is first raised by a window with only three COM symbols. The next window then places its four COM symbols on units 197 to 200, so the fourth one coincides with the window end. After that edge `idle_o` is expected to be 0. A second overlap is a configuration change part-way through a window: the bench checks that the new window runs its full length from the change and does not end at the old boundary.

// File: rtl/rxei_pkg.sv
// Package: shared types for the receiver idle inference block.
// Assumes: nothing beyond the standard language.
package rxei_pkg;

    // How the current window is paced, or whether timing is bypassed.
    typedef enum logic [1:0] {
        WIN_PASS = 2'd0,   // output repeats the idle-ordered-set flag
        WIN_OFF  = 2'd1,   // output held low
        WIN_CYC  = 2'd2,   // window counted in clock cycles
        WIN_SYM  = 2'd3    // window counted in valid symbols
    } win_kind_e;

    // Which event satisfies a window.
    typedef enum logic [1:0] {
        NEED_SKP = 2'd0,
        NEED_TS  = 2'd1,
        NEED_COM = 2'd2
    } need_e;

    typedef struct packed {
        win_kind_e kind;
        need_e     need;
    } win_plan_t;

endpackage

// File: rtl/rxei_mode_decode.sv
// Module: rxei_mode_decode
// Maps the link-state select and rate onto a window plan: pacing kind,
// required event and window length. Purely combinational.
// Assumes: len fits in CW bits for every parameter value.
module rxei_mode_decode
    import rxei_pkg::*;
#(
    parameter int CW        = 16,
    parameter int US_CYCLES = 32000,
    parameter int SYM_TS    = 128,
    parameter int SYM_G1    = 200,
    parameter int SYM_G2    = 1600
) (
    input  logic [2:0]    sel,
    input  logic          gen2,
    output win_plan_t     plan,
    output logic [CW-1:0] len
);

    // Select-code lookup for the window plan.
    always_comb begin
        plan.kind = WIN_PASS;
        plan.need = NEED_SKP;
        len       = CW'(SYM_TS);
        case (sel)
            3'b100: begin
                plan.kind = WIN_CYC;
                plan.need = NEED_SKP;
                len       = CW'(US_CYCLES);
            end
            3'b101: begin
                plan.kind = WIN_SYM;
                plan.need = NEED_TS;
                len       = CW'(SYM_TS);
            end
            3'b110: begin
                plan.kind = WIN_SYM;
                plan.need = NEED_COM;
                len       = gen2 ? CW'(SYM_G2) : CW'(SYM_G1);
            end
            3'b111: begin
                plan.kind = gen2 ? WIN_OFF : WIN_CYC;
                plan.need = NEED_COM;
                len       = CW'(US_CYCLES);
            end
            default: begin
                plan.kind = WIN_PASS;
                plan.need = NEED_SKP;
                len       = CW'(SYM_TS);
            end
        endcase
    end

endmodule

// File: rtl/rxei_window_timer.sv
// Module: rxei_window_timer
// Counts pacing ticks and flags the last tick of each window. Windows
// follow each other with no gap. A restart puts the count back to zero
// and suppresses the window end in that cycle.
// Assumes: len >= 1 and len stays stable except across a restart.
module rxei_window_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] len,
    output logic          win_end,
    output logic [CW-1:0] pos
);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == len - CW'(1));
    assign win_end = tick && !restart && at_last;
    assign pos     = cnt_q;

    // Window position counter, wrapping at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_last ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/rxei_need_tracker.sv
// Module: rxei_need_tracker
// Watches valid symbols for the event the current mode requires. For
// COM it counts to COM_NEED; for skip or TS a single flag is enough.
// hit marks the cycle the requirement is met; met covers the whole window
// including this cycle.
// Assumes: COM_NEED >= 1; clear and win_end both start a fresh window.
module rxei_need_tracker
    import rxei_pkg::*;
#(
    parameter int COM_NEED = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  win_end,
    input  need_e need,
    input  logic  sym_valid,
    input  logic  com_seen,
    input  logic  skp_done,
    input  logic  ts_done,
    output logic  hit,
    output logic  met
);

    localparam int NW = $clog2(COM_NEED + 1);

    logic [NW-1:0] com_cnt_q;
    logic          met_q;
    logic          com_now;
    logic          com_room;

    assign com_now  = sym_valid && com_seen;
    assign com_room = (com_cnt_q < NW'(COM_NEED));

    // Requirement reached in this cycle.
    always_comb begin
        case (need)
            NEED_SKP: hit = sym_valid && skp_done;
            NEED_TS:  hit = sym_valid && ts_done;
            NEED_COM: hit = com_now && (com_cnt_q == NW'(COM_NEED - 1));
            default:  hit = 1'b0;
        endcase
    end

    assign met = met_q || hit;

    // Per-window COM count and satisfied flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || win_end) begin
            com_cnt_q <= '0;
            met_q     <= 1'b0;
        end else begin
            if (com_now && com_room) begin
                com_cnt_q <= com_cnt_q + NW'(1);
            end
            if (hit) begin
                met_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_idle_infer.sv
// Module: rx_idle_infer (top)
// Infers receiver electrical idle from missing traffic in timed windows
// chosen by the link-state select and rate. A select with its top bit
// clear bypasses the timing, and the output repeats the idle-ordered-set flag.
// Assumes: one 10-bit symbol per sym_valid; US_CYCLES is 128 us in receive
// clocks; all inputs synchronous to clk.
module rx_idle_infer
    import rxei_pkg::*;
#(
    parameter int US_CYCLES = 32000,
    parameter int SYM_TS    = 128,
    parameter int SYM_G1    = 200,
    parameter int SYM_G2    = 1600,
    parameter int COM_NEED  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic       com_seen,
    input  logic       skp_done,
    input  logic       ts_done,
    input  logic       eios_seen,
    input  logic [2:0] mode_sel,
    input  logic       rate_gen2,
    output logic       idle_o
);

    localparam int MAX_A  = (US_CYCLES > SYM_G2) ? US_CYCLES : SYM_G2;
    localparam int MAX_B  = (SYM_G1 > SYM_TS) ? SYM_G1 : SYM_TS;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAXLEN + 1);

    win_plan_t     plan;
    logic [CW-1:0] win_len;
    logic [CW-1:0] win_pos;
    logic [3:0]    cfg_now;
    logic [3:0]    cfg_q;
    logic          cfg_chg;
    logic          tick;
    logic          win_end;
    logic          need_hit;
    logic          need_met;
    logic          idle_q;

    assign cfg_now = {mode_sel, rate_gen2};
    assign cfg_chg = (cfg_now != cfg_q);
    assign tick    = (plan.kind == WIN_CYC) || ((plan.kind == WIN_SYM) && sym_valid);
    assign idle_o  = idle_q;

    rxei_mode_decode #(
        .CW        (CW),
        .US_CYCLES (US_CYCLES),
        .SYM_TS    (SYM_TS),
        .SYM_G1    (SYM_G1),
        .SYM_G2    (SYM_G2)
    ) u_decode (
        .sel  (mode_sel),
        .gen2 (rate_gen2),
        .plan (plan),
        .len  (win_len)
    );

    rxei_window_timer #(
        .CW (CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_chg),
        .tick    (tick),
        .len     (win_len),
        .win_end (win_end),
        .pos     (win_pos)
    );

    rxei_need_tracker #(
        .COM_NEED (COM_NEED)
    ) u_need (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_chg),
        .win_end   (win_end),
        .need      (plan.need),
        .sym_valid (sym_valid),
        .com_seen  (com_seen),
        .skp_done  (skp_done),
        .ts_done   (ts_done),
        .hit       (need_hit),
        .met       (need_met)
    );

    // Remember the last configuration to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    // Idle decision: bypass, forced low, window expiry or event clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else if (plan.kind == WIN_PASS) begin
            idle_q <= eios_seen;
        end else if (cfg_chg || (plan.kind == WIN_OFF)) begin
            idle_q <= 1'b0;
        end else if (win_end && !need_met) begin
            idle_q <= 1'b1;
        end else if (need_hit) begin
            idle_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rxei_checker.sv
// Module: rxei_checker
// Temporal properties of the idle inference top, attached by bind.
// Assumes: connected to the top's ports and its internal window signals.
module rxei_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sym_valid,
    input logic          com_seen,
    input logic          eios_seen,
    input logic [2:0]    mode_sel,
    input logic          rate_gen2,
    input logic          idle_o,
    input logic          cfg_chg,
    input logic          win_end,
    input logic          need_hit,
    input logic [CW-1:0] win_pos
);

    // R1: reset drives the output low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !idle_o);

    // R2: bypass mode repeats the idle-ordered-set flag one cycle later.
    a_r2_follow_eios: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel[2] |=> (idle_o == $past(eios_seen)));

    // R3..R6: in timed modes idle can only rise at a window end.
    a_r3_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[2] && !idle_o && !win_end) |=> !idle_o);

    // R7: loopback at Gen2 keeps idle low.
    a_r7_gen2_loop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b111 && rate_gen2) |=> !idle_o);

    // R8: in COM modes idle only falls on a valid COM or a config change.
    a_r8_fall_needs_com: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[2] && mode_sel[1] && idle_o && !cfg_chg && !(sym_valid && com_seen))
        |=> idle_o);

    // R10: the expected event clears idle on the next edge.
    a_r10_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[2] && need_hit) |=> !idle_o);

    // R11: a configuration change into a timed mode clears idle.
    a_r11_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[2] && cfg_chg) |=> !idle_o);

    // R12: symbol-paced windows hold their position without a symbol.
    a_r12_hold_no_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == 3'b101 || mode_sel == 3'b110) && !sym_valid && !cfg_chg)
        |=> $stable(win_pos));

endmodule

bind rx_idle_infer rxei_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .com_seen  (com_seen),
    .eios_seen (eios_seen),
    .mode_sel  (mode_sel),
    .rate_gen2 (rate_gen2),
    .idle_o    (idle_o),
    .cfg_chg   (cfg_chg),
    .win_end   (win_end),
    .need_hit  (need_hit),
    .win_pos   (win_pos)
);

// File: tb/tb_rx_idle_infer.sv
// Scoreboard bench: driver tasks queue the expected idle value for each
// cycle they drive; a monitor pops and compares after each edge.
module tb_rx_idle_infer;

    localparam int US  = 40;
    localparam int NCOM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic       com_seen = 1'b0;
    logic       skp_done = 1'b0;
    logic       ts_done = 1'b0;
    logic       eios_seen = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       rate_gen2 = 1'b0;
    logic       idle_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic cur_idle = 1'b0;
    logic done = 1'b0;

    typedef struct {
        int    due;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    rx_idle_infer #(
        .US_CYCLES (US),
        .SYM_TS    (128),
        .SYM_G1    (200),
        .SYM_G2    (1600),
        .COM_NEED  (NCOM)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .com_seen  (com_seen),
        .skp_done  (skp_done),
        .ts_done   (ts_done),
        .eios_seen (eios_seen),
        .mode_sel  (mode_sel),
        .rate_gen2 (rate_gen2),
        .idle_o    (idle_o)
    );

    // Monitor: compare queued expectations shortly after each edge.
    always @(posedge clk) begin
        #3;
        while (sb.size() > 0 && sb[0].due == cyc) begin : pop_one
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (idle_o !== e.val) begin
                fails++;
                $display("FAIL %s cycle=%0d idle_o=%0b expected=%0b", e.tag, cyc, idle_o, e.val);
            end
        end
    end

    // One clock: inputs already set, wait the edge, return at negedge.
    task automatic step();
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    // Drive one cycle and queue the idle value expected after its edge.
    task automatic drv(input logic sv, input logic c, input logic s, input logic t,
                       input logic ei, input logic exp_v, input string tag);
        exp_t e;
        e.due = cyc + 1;
        e.val = exp_v;
        e.tag = tag;
        sb.push_back(e);
        sym_valid = sv;
        com_seen  = c;
        skp_done  = s;
        ts_done   = t;
        eios_seen = ei;
        step();
    endtask

    // Switch configuration; the change cycle itself clears idle (R11).
    task automatic set_cfg(input logic [2:0] s, input logic g);
        mode_sel  = s;
        rate_gen2 = g;
        cur_idle  = 1'b0;
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11 config change");
    endtask

    // One window of valid symbols, COM on units c0..c0+ncom-1.
    task automatic com_window(input int len, input int c0, input int ncom,
                              input logic ei, input string tag);
        int   got;
        logic met;
        got = 0;
        met = 1'b0;
        for (int i = 1; i <= len; i++) begin
            logic c;
            c = (ncom > 0) && (i >= c0) && (i < c0 + ncom);
            if (c) got++;
            if (c && got == NCOM) begin
                met = 1'b1;
                cur_idle = 1'b0;
            end
            if (i == len && !met) cur_idle = 1'b1;
            drv(1'b1, c, 1'b0, 1'b0, ei, cur_idle, tag);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 reset");
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 reset");
        rst_n = 1'b1;

        // R2: bypass follows the idle-ordered-set flag
        set_cfg(3'b010, 1'b0);
        drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R2 eios high");
        drv(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2 eios low");
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R2 eios without symbol");
        set_cfg(3'b011, 1'b1);
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R2 gen2 eios high");
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 gen2 eios low");

        // R3: skip window in cycles, Gen1
        set_cfg(3'b100, 1'b0);
        com_window(US, 0, 0, 1'b0, "R3 no skip gen1");
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9 skip without symbol ignored");
        drv(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 skip clears");
        cur_idle = 1'b0;
        for (int i = 0; i < US - 2; i++)
            drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 window with skip stays low");
        com_window(US, 0, 0, 1'b0, "R3 next quiet window");
        // R3: Gen2
        set_cfg(3'b100, 1'b1);
        com_window(US, 0, 0, 1'b1, "R3 no skip gen2");

        // R4/R12: TS window in symbols with gaps
        set_cfg(3'b101, 1'b0);
        for (int i = 1; i <= 128; i++) begin
            drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R12 gap does not advance");
            drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, (i == 128), "R4 no TS in 128 symbols");
        end
        drv(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 TS clears");
        cur_idle = 1'b0;
        for (int i = 0; i < 127; i++)
            drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 window with TS stays low");
        com_window(128, 0, 0, 1'b0, "R4 next quiet window");

        // R11: rate change mid-window restarts the window
        set_cfg(3'b101, 1'b1);
        for (int i = 0; i < 100; i++)
            drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 gen2 partial window");
        set_cfg(3'b101, 1'b0);
        com_window(128, 0, 0, 1'b0, "R11 full window after change");

        // R5/R8/R9/R10: COM windows, Gen1
        set_cfg(3'b110, 1'b0);
        com_window(200, 1, 3, 1'b0, "R8 three COM -> idle");
        com_window(200, 1, 4, 1'b0, "R8 four COM clears");
        com_window(200, 50, 3, 1'b1, "R9 eios ignored, three COM");
        com_window(200, 197, 4, 1'b0, "R10 fourth COM on window end");
        // R5: Gen2 window length
        set_cfg(3'b110, 1'b1);
        com_window(1600, 10, 3, 1'b0, "R5 gen2 1600 symbols");

        // R6: loopback Gen1, cycle window
        set_cfg(3'b111, 1'b0);
        com_window(US, 1, 3, 1'b0, "R6 three COM -> idle");
        com_window(US, 5, 4, 1'b0, "R6 four COM clears");

        // R7: loopback Gen2 stays low
        set_cfg(3'b111, 1'b1);
        for (int i = 0; i < 100; i++)
            drv(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7 gen2 loopback low");

        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 final");
        step();
        step();
        if (sb.size() != 0) begin
            fails++;
            checks++;
            $display("FAIL scoreboard left=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule